// File: doc/BRIEF.md
# Cascaded Baud Tick Generator

This block derives serial-line timing from the system clock. Three counting stages run in a chain. First, a selectable divide-by-8 prescaler produces the "selected clock" as a clock-enable. Second, a 16-bit clock divisor counts selected-clock enables and emits a sample tick. Third, an 8-bit bit divisor counts sample ticks and emits a bit tick. The resulting bit rate is `f_clk / (P * CD * (BDIV + 1))`, where P is 1 or 8.

All timing is carried as single-cycle enable pulses in the system clock domain. No derived clock is created. A receiver or transmitter shifter elsewhere uses `sample_tick_o` as its oversampling strobe and `bit_tick_o` as its bit boundary. The block moves no data stream, so there is no valid/ready handshake and back-pressure does not apply. Every pin is a plain level control or a pulse.

A change to any setting restarts all three stages from zero, so a stretched or truncated period is never emitted. Enabling the block has the same effect. Software would normally program CD between 2 and 65535 and BDIV between 4 and 254. The hardware also defines its behaviour for smaller values.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, both `sample_tick_o` and `bit_tick_o` are 0.
- R2: With `prescale_sel_i` = 1, the selected clock advances once every 8 system cycles. With `prescale_sel_i` = 0, it advances every cycle. This scales every sample period by 8.
- R3: With CD (`clk_div_i`) of 2 or more, `sample_tick_o` pulses once every P*CD system cycles, where P = 8 if `prescale_sel_i` = 1 and 1 otherwise.
- R4: A CD of 1 bypasses the divisor: one sample tick per selected-clock enable, which is every P cycles.
- R5: A CD of 0 stops tick generation: neither output ever pulses.
- R6: `bit_tick_o` pulses on every (BDIV+1)-th sample tick, always in the same cycle as a sample tick. A BDIV of 0 makes both ticks identical.
- R7: When `enable_i`, `prescale_sel_i`, `clk_div_i` or `bit_div_i` changes, no tick is issued in the cycle the change is seen, and all counters restart from zero. The first sample tick then appears P*CD+1 cycles after the edge that sees the change, and the first bit tick appears P*CD*(BDIV+1)+1 cycles after that edge. A tick that was due in the change cycle is dropped.
- R8: While `enable_i` is 0, neither output pulses. Raising `enable_i` restarts the timing as in R7.
- R9: Whenever the sample period P*CD exceeds 1, each tick is high for exactly one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Run enable; low holds all stages idle |
| prescale_sel_i | input | 1 | 1 selects the divide-by-8 prescaler |
| clk_div_i | input | 16 | Clock divisor CD (0 stops, 1 bypasses) |
| bit_div_i | input | 8 | Bit divisor BDIV; bit tick every BDIV+1 sample ticks |
| sample_tick_o | output | 1 | One-cycle sample-clock pulse |
| bit_tick_o | output | 1 | One-cycle bit-boundary pulse |

## Verification
A configuration restart and a due bit tick can land in the same cycle. R7 requires the restart to win and the tick to be dropped. The bench runs each setting for exactly two bit periods and then loads the next setting, so every reconfiguration arrives on the interval in which a bit tick would have fired. The bench judges this by requiring both outputs to be low in the first sample of the new run, and by requiring the first new tick at the full restart latency.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // default widths and prescale ratio of the tick generator
  localparam int unsigned CD_WIDTH_DEF   = 16;
  localparam int unsigned BD_WIDTH_DEF   = 8;
  localparam int unsigned PRESCALE_DEF   = 8;

  // counter width needed to count 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned DIV = baud_pkg::PRESCALE_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic sel_i,
  output logic pre_en_o
);
  localparam int unsigned W = baud_pkg::cnt_width(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap     = (cnt_q == LAST);
  assign pre_en_o = !clr_i && (sel_i ? wrap : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i || !sel_i) cnt_q <= '0;
    else if (wrap)                 cnt_q <= '0;
    else                           cnt_q <= cnt_q + W'(1);
  end

  // R2
  presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !clr_i && pre_en_o) |=> !pre_en_o);
endmodule

// File: rtl/baud_clk_div.sv
module baud_clk_div #(
  parameter int unsigned W = baud_pkg::CD_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         pre_en_i,
  input  logic [W-1:0] cd_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic         active;

  assign active = (cd_i != '0);
  assign hit_o  = !clr_i && pre_en_i && active && (cnt_q == cd_i - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)        cnt_q <= '0;
    else if (pre_en_i && active) begin
      if (hit_o) cnt_q <= '0;
      else       cnt_q <= cnt_q + W'(1);
    end
  end

  // R5
  cd_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_i == '0) |-> !hit_o);
  // R7
  cd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned W = baud_pkg::BD_WIDTH_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         smp_i,
  input  logic [W-1:0] bd_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = !clr_i && smp_i && (cnt_q == bd_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (smp_i) begin
      if (hit_o) cnt_q <= '0;
      else       cnt_q <= cnt_q + W'(1);
    end
  end

  // R6
  bit_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> smp_i);
  // R7
  bd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned CD_W     = baud_pkg::CD_WIDTH_DEF,
  parameter int unsigned BD_W     = baud_pkg::BD_WIDTH_DEF,
  parameter int unsigned PRESCALE = baud_pkg::PRESCALE_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic            prescale_sel_i,
  input  logic [CD_W-1:0] clk_div_i,
  input  logic [BD_W-1:0] bit_div_i,
  output logic            sample_tick_o,
  output logic            bit_tick_o
);
  localparam int unsigned CFG_W = 2 + CD_W + BD_W;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_chg, clr;
  logic             pre_en, smp_hit, bit_hit;

  assign cfg_now = {enable_i, prescale_sel_i, clk_div_i, bit_div_i};
  assign cfg_chg = (cfg_now != cfg_q);
  assign clr     = !enable_i || cfg_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  baud_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .sel_i(prescale_sel_i),
    .pre_en_o(pre_en)
  );

  baud_clk_div #(.W(CD_W)) u_cd (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .pre_en_i(pre_en),
    .cd_i(clk_div_i), .hit_o(smp_hit)
  );

  baud_bit_div #(.W(BD_W)) u_bd (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .smp_i(smp_hit),
    .bd_i(bit_div_i), .hit_o(bit_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_tick_o <= 1'b0;
      bit_tick_o    <= 1'b0;
    end else begin
      sample_tick_o <= smp_hit;
      bit_tick_o    <= bit_hit;
    end
  end

  // R8
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!sample_tick_o && !bit_tick_o));
  // R6
  bit_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> sample_tick_o);
  // R7
  change_drops_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !sample_tick_o);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic        prescale_sel_i = 1'b0;
  logic [15:0] clk_div_i = '0;
  logic [7:0]  bit_div_i = '0;
  logic        sample_tick_o, bit_tick_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;  // 250 MHz

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
    .prescale_sel_i(prescale_sel_i), .clk_div_i(clk_div_i),
    .bit_div_i(bit_div_i), .sample_tick_o(sample_tick_o),
    .bit_tick_o(bit_tick_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // apply a setting at a negedge, then compare N samples taken at negedges
  task automatic run(input logic en, input logic sel, input int cd,
                     input int bd, input int n);
    int  p, pcd, pb;
    logic prev_s;
    enable_i = en; prescale_sel_i = sel;
    clk_div_i = 16'(cd); bit_div_i = 8'(bd);
    p = sel ? 8 : 1;
    pcd = p * cd;
    pb = pcd * (bd + 1);
    prev_s = 1'b0;
    for (int i = 1; i <= n; i++) begin
      logic es, eb;
      string tag;
      @(negedge clk);
      es = en && (cd != 0) && ((i - 1) >= pcd) && (((i - 1) % pcd) == 0);
      eb = es && (((i - 1) % pb) == 0);
      if (!en)              tag = "R8";
      else if (cd == 0)     tag = "R5";
      else if (i <= pcd + 1) tag = "R7";
      else if (cd == 1)     tag = "R4";
      else if (sel)         tag = "R2";
      else                  tag = "R3";
      check(tag, sample_tick_o, es);
      check("R6", bit_tick_o, eb);
      if (pcd > 1 && prev_s) check("R9", sample_tick_o, 1'b0);
      prev_s = sample_tick_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", sample_tick_o, 1'b0);
    check("R1", bit_tick_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", sample_tick_o, 1'b0);
    check("R1", bit_tick_o, 1'b0);
    // disabled with a live setting, then enable rise restarts
    run(1'b0, 1'b0, 3, 1, 40);
    run(1'b1, 1'b0, 3, 1, 2 * 3 * 2);
    // sweep: each run lasts exactly two bit periods so the next change
    // lands on the interval where a bit tick is due
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 5; c++) begin
        for (int b = 0; b < 4; b++) begin
          int cdv, bdv, pb;
          cdv = (c == 4) ? 5 : c;
          bdv = (b == 3) ? 4 : b;
          pb = (s ? 8 : 1) * cdv * (bdv + 1);
          run(1'b1, s[0], cdv, bdv, (cdv == 0) ? 40 : 2 * pb);
        end
      end
    end
    // mid-period change of divisor only
    run(1'b1, 1'b0, 7, 2, 10);
    run(1'b1, 1'b0, 4, 2, 2 * 4 * 3);
    run(1'b0, 1'b0, 4, 2, 20);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule